// File: doc/BRIEF.md
# Conditional Call and Return Unit

This block carries out the two control-flow opcodes of a fixed-length virtual machine program: a forward subroutine call and a return. Each accepted instruction supplies operand A, the low 32 bits of operand B, the location code of B, an 8-bit and a 32-bit immediate, and the index of the current instruction. One cycle later the block reports the index of the next instruction to run and whether and with what value destination C is written.

Branching is conditional. The block compares B, as an unsigned number, with the 32-bit immediate. When B comes from an immediate location, the branch is unconditional. A taken call stores A and the return index as one entry on an internal hardware stack, and then jumps forward by a short wrapped offset. A taken return removes the newest entry, writes A XOR the stored value to C, and resumes at the stored index. A branch that is not taken only copies A to C. A return made while the stack is empty is never taken. A call made while the stack is full is refused and flagged.

Top module: `callret_unit`

## Requirements
- R1: After reset, `res_valid`, `c_we` and `stk_overflow` are 0 and `stk_empty` is 1.
- R2: With a register location for B (`b_loc` 0 to 5), the branch condition is `opb_lo <= imm32` as an unsigned 32-bit compare. Equality counts as taken, and 0xFFFFFFFF against 0x7FFFFFFF is not taken.
- R3: With `b_loc` equal to 6 or 7, the condition is always true, whatever `opb_lo` and `imm32` hold.
- R4: A call or return that is not taken gives `c_we`=1, `c_value`=A and `next_pc`=(`pc`+1) mod PROG_LEN.
- R5: A taken call gives `c_we`=0 and `next_pc`=(`pc` + 2 + `imm8`[6:0]) mod PROG_LEN. Bit 7 of `imm8` has no effect.
- R6: A taken call pushes the pair {A, (`pc`+1) mod PROG_LEN}, so `stk_empty` is 0 in its result cycle.
- R7: A return while `stk_empty` is 1 is not taken, even when the condition holds.
- R8: A taken return pops the newest pair {V, P} and gives `c_we`=1, `c_value`=A XOR V and `next_pc`=P. Pairs come back last-in first-out.
- R9: A call whose condition holds while the stack already holds STACK_DEPTH pairs is treated as not taken (R4 outputs) and raises `stk_overflow` in its result cycle. The stack contents are unchanged.
- R10: The result of an instruction accepted on `instr_valid` appears with `res_valid`=1 exactly one cycle later. Instructions may be issued on back-to-back cycles, and `res_valid` is 0 one cycle after a cycle with no instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction present this cycle |
| op_ret | input | 1 | 0 = call, 1 = return |
| opa | input | DATA_W | Operand A |
| opb_lo | input | 32 | Low 32 bits of operand B |
| b_loc | input | 3 | Location code of B; 6 and 7 mean immediate |
| imm8 | input | 8 | Short immediate; bits 6:0 give the call offset |
| imm32 | input | 32 | Comparison immediate |
| pc | input | PC_W | Index of the current instruction |
| res_valid | output | 1 | Result outputs valid |
| next_pc | output | PC_W | Index of the next instruction |
| c_value | output | DATA_W | Value for destination C |
| c_we | output | 1 | Write C this result |
| stk_empty | output | 1 | Stack holds no pair |
| stk_overflow | output | 1 | This result was a call refused on a full stack |

## Verification
The hardest situation to reach is a call refused on a full stack, because the condition must hold on STACK_DEPTH consecutive calls first. The stimulus therefore issues a back-to-back run of immediate-location calls to fill the stack. It then issues one more call and a return, which shows that the refused call left the newest entry in place. Returns on an empty stack are reached by draining the stack completely. The same drain also exercises last-in first-out order and a return index that wraps to zero.

// File: rtl/cru_pkg.sv
package cru_pkg;

  typedef enum logic {
    CRU_CALL = 1'b0,
    CRU_RET  = 1'b1
  } cru_op_e;

  typedef enum logic [1:0] {
    ACT_NOP    = 2'd0,
    ACT_PUSH   = 2'd1,
    ACT_POP    = 2'd2,
    ACT_REFUSE = 2'd3
  } cru_act_e;

  function automatic logic loc_is_imm(input logic [2:0] loc);
    return loc[2] & loc[1];
  endfunction

endpackage

// File: rtl/cru_decide.sv
module cru_decide
  import cru_pkg::*;
#(
  parameter int CMP_W = 32
) (
  input  logic             valid,
  input  cru_op_e          op,
  input  logic [2:0]       b_loc,
  input  logic [CMP_W-1:0] opb_lo,
  input  logic [CMP_W-1:0] imm32,
  input  logic             stk_full,
  input  logic             stk_empty,
  output cru_act_e         act
);
  logic cond;

  always_comb begin
    cond = loc_is_imm(b_loc) || (opb_lo <= imm32);
    act  = ACT_NOP;
    if (valid && cond) begin
      if (op == CRU_CALL) begin
        act = stk_full ? ACT_REFUSE : ACT_PUSH;
      end else if (!stk_empty) begin
        act = ACT_POP;
      end
    end
  end
endmodule

// File: rtl/cru_stack.sv
module cru_stack #(
  parameter int DATA_W = 64,
  parameter int PC_W   = 8,
  parameter int DEPTH  = 16,
  localparam int ENT_W = DATA_W + PC_W,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SP_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] push_val,
  input  logic [PC_W-1:0]   push_pc,
  output logic [DATA_W-1:0] top_val,
  output logic [PC_W-1:0]   top_pc,
  output logic              full,
  output logic              empty
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [SP_W-1:0]  sp;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [ENT_W-1:0] top_ent;

  assign wr_idx  = IDX_W'(sp);
  assign rd_idx  = IDX_W'(sp - 1'b1);
  assign full    = (sp == SP_W'(DEPTH));
  assign empty   = (sp == '0);
  assign top_ent = mem[rd_idx];
  assign top_val = top_ent[ENT_W-1:PC_W];
  assign top_pc  = top_ent[PC_W-1:0];

  // storage array: no reset, single write port
  always_ff @(posedge clk) begin
    if (push && !full) begin
      mem[wr_idx] <= {push_val, push_pc};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (push && !full) begin
      sp <= sp + 1'b1;
    end else if (pop && !empty) begin
      sp <= sp - 1'b1;
    end
  end
endmodule

// File: rtl/cru_target.sv
module cru_target #(
  parameter int PC_W  = 8,
  parameter int OFS_W = 7
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFS_W-1:0] ofs,
  output logic [PC_W-1:0]  pc_inc,
  output logic [PC_W-1:0]  pc_jump
);
  localparam int SUM_W = ((PC_W > OFS_W) ? PC_W : OFS_W) + 2;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum     = SUM_W'(pc) + SUM_W'(ofs) + SUM_W'(2);
    pc_inc  = pc + 1'b1;
    pc_jump = sum[PC_W-1:0];
  end
endmodule

// File: rtl/callret_unit.sv
module callret_unit
  import cru_pkg::*;
#(
  parameter int PROG_LEN    = 256,
  parameter int STACK_DEPTH = 16,
  parameter int DATA_W      = 64,
  localparam int PC_W       = $clog2(PROG_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic              op_ret,
  input  logic [DATA_W-1:0] opa,
  input  logic [31:0]       opb_lo,
  input  logic [2:0]        b_loc,
  input  logic [7:0]        imm8,
  input  logic [31:0]       imm32,
  input  logic [PC_W-1:0]   pc,
  output logic              res_valid,
  output logic [PC_W-1:0]   next_pc,
  output logic [DATA_W-1:0] c_value,
  output logic              c_we,
  output logic              stk_empty,
  output logic              stk_overflow
);
  cru_act_e          act;
  cru_op_e           op;
  logic              full;
  logic [DATA_W-1:0] top_val;
  logic [PC_W-1:0]   top_pc;
  logic [PC_W-1:0]   pc_inc;
  logic [PC_W-1:0]   pc_jump;
  logic              unused_imm_hi;

  assign op            = op_ret ? CRU_RET : CRU_CALL;
  assign unused_imm_hi = imm8[7];

  cru_decide #(.CMP_W(32)) u_decide (
    .valid     (instr_valid),
    .op        (op),
    .b_loc     (b_loc),
    .opb_lo    (opb_lo),
    .imm32     (imm32),
    .stk_full  (full),
    .stk_empty (stk_empty),
    .act       (act)
  );

  cru_stack #(.DATA_W(DATA_W), .PC_W(PC_W), .DEPTH(STACK_DEPTH)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (act == ACT_PUSH),
    .pop      (act == ACT_POP),
    .push_val (opa),
    .push_pc  (pc_inc),
    .top_val  (top_val),
    .top_pc   (top_pc),
    .full     (full),
    .empty    (stk_empty)
  );

  cru_target #(.PC_W(PC_W), .OFS_W(7)) u_target (
    .pc      (pc),
    .ofs     (imm8[6:0]),
    .pc_inc  (pc_inc),
    .pc_jump (pc_jump)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid    <= 1'b0;
      next_pc      <= '0;
      c_value      <= '0;
      c_we         <= 1'b0;
      stk_overflow <= 1'b0;
    end else begin
      res_valid    <= instr_valid;
      c_we         <= 1'b0;
      stk_overflow <= 1'b0;
      if (instr_valid) begin
        case (act)
          ACT_PUSH: begin
            next_pc <= pc_jump;
            c_value <= opa;
          end
          ACT_POP: begin
            next_pc <= top_pc;
            c_value <= opa ^ top_val;
            c_we    <= 1'b1;
          end
          ACT_REFUSE: begin
            next_pc      <= pc_inc;
            c_value      <= opa;
            c_we         <= 1'b1;
            stk_overflow <= 1'b1;
          end
          default: begin
            next_pc <= pc_inc;
            c_value <= opa;
            c_we    <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/cru_checker.sv
module cru_checker #(
  parameter int PC_W   = 8,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic              op_ret,
  input logic [DATA_W-1:0] opa,
  input logic [31:0]       opb_lo,
  input logic [2:0]        b_loc,
  input logic [31:0]       imm32,
  input logic [PC_W-1:0]   pc,
  input logic              res_valid,
  input logic [PC_W-1:0]   next_pc,
  input logic [DATA_W-1:0] c_value,
  input logic              c_we,
  input logic              stk_empty,
  input logic              stk_overflow
);
  // R1
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!res_valid && !c_we && !stk_overflow && stk_empty));

  // R4 with R2: register compare fails
  p_not_taken_r4: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !(b_loc[2] && b_loc[1]) && (opb_lo > imm32))
    |=> (res_valid && c_we && c_value == $past(opa)
         && next_pc == PC_W'($past(pc) + 1'b1)));

  // R3: immediate location always taken, unless a call is refused
  p_imm_call_r3: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !op_ret && b_loc[2] && b_loc[1])
    |=> (res_valid && (c_we == stk_overflow)));

  // R6
  p_push_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !c_we) |-> !stk_empty);

  // R7
  p_empty_ret_r7: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && op_ret && stk_empty)
    |=> (c_we && !stk_overflow && c_value == $past(opa)
         && next_pc == PC_W'($past(pc) + 1'b1)));

  // R9
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    stk_overflow |-> (res_valid && c_we && !stk_empty));

  // R10
  p_issue_latency_r10: assert property (@(posedge clk) disable iff (rst)
    instr_valid |=> res_valid);
  p_idle_latency_r10: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> !res_valid);
endmodule

bind callret_unit cru_checker #(.PC_W(PC_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .instr_valid  (instr_valid),
  .op_ret       (op_ret),
  .opa          (opa),
  .opb_lo       (opb_lo),
  .b_loc        (b_loc),
  .imm32        (imm32),
  .pc           (pc),
  .res_valid    (res_valid),
  .next_pc      (next_pc),
  .c_value      (c_value),
  .c_we         (c_we),
  .stk_empty    (stk_empty),
  .stk_overflow (stk_overflow)
);

// File: tb/test_callret_unit.sv
module test_callret_unit;
  localparam int PL    = 256;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic        op_ret = 1'b0;
  logic [63:0] opa = '0;
  logic [31:0] opb_lo = '0;
  logic [2:0]  b_loc = '0;
  logic [7:0]  imm8 = '0;
  logic [31:0] imm32 = '0;
  logic [7:0]  pc = '0;
  logic        res_valid;
  logic [7:0]  next_pc;
  logic [63:0] c_value;
  logic        c_we;
  logic        stk_empty;
  logic        stk_overflow;

  always #10 clk = ~clk;

  callret_unit #(.PROG_LEN(PL), .STACK_DEPTH(DEPTH), .DATA_W(64)) i_callret_unit (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .op_ret(op_ret),
    .opa(opa), .opb_lo(opb_lo), .b_loc(b_loc), .imm8(imm8), .imm32(imm32),
    .pc(pc), .res_valid(res_valid), .next_pc(next_pc), .c_value(c_value),
    .c_we(c_we), .stk_empty(stk_empty), .stk_overflow(stk_overflow)
  );

  typedef struct {
    logic [7:0]  npc;
    logic [63:0] cv;
    logic        we;
    logic        ovf;
    logic        emp;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;

  logic [63:0] m_val [DEPTH];
  logic [7:0]  m_pc  [DEPTH];
  int          m_sp = 0;

  task automatic issue(input logic ret, input logic [63:0] a, input logic [31:0] b,
                       input logic [2:0] loc, input logic [7:0] i8,
                       input logic [31:0] i32, input logic [7:0] p, input string tag);
    exp_t e;
    logic cond;
    cond  = (loc >= 3'd6) || (b <= i32);
    e.npc = 8'((int'(p) + 1) % PL);
    e.cv  = a;
    e.we  = 1'b1;
    e.ovf = 1'b0;
    if (!ret && cond) begin
      if (m_sp < DEPTH) begin
        m_val[m_sp] = a;
        m_pc[m_sp]  = 8'((int'(p) + 1) % PL);
        m_sp++;
        e.npc = 8'((int'(p) + 2 + int'(i8[6:0])) % PL);
        e.we  = 1'b0;
      end else begin
        e.ovf = 1'b1;
      end
    end else if (ret && cond && m_sp > 0) begin
      m_sp--;
      e.cv  = a ^ m_val[m_sp];
      e.npc = m_pc[m_sp];
    end
    e.emp = (m_sp == 0);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    op_ret = ret; opa = a; opb_lo = b; b_loc = loc; imm8 = i8; imm32 = i32; pc = p;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      exp_t  e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected result: res_valid=1 expected 0");
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (c_we !== e.we || next_pc !== e.npc || stk_overflow !== e.ovf ||
            stk_empty !== e.emp || (e.we && c_value !== e.cv)) begin
          errors++;
          $display("FAIL %s got we=%0b pc=%0d c=%h ovf=%0b emp=%0b exp we=%0b pc=%0d c=%h ovf=%0b emp=%0b",
                   t, c_we, next_pc, c_value, stk_overflow, stk_empty,
                   e.we, e.npc, e.cv, e.ovf, e.emp);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    checks++;
    if (res_valid !== 1'b0 || c_we !== 1'b0 || stk_overflow !== 1'b0 || stk_empty !== 1'b1) begin
      errors++;
      $display("FAIL R1 got v=%0b we=%0b ovf=%0b emp=%0b exp 0 0 0 1",
               res_valid, c_we, stk_overflow, stk_empty);
    end
    issue(1'b0, 64'hA1, 32'd5,  3'd0, 8'h05, 32'd10, 8'd3,  "R2 call b<imm");
    issue(1'b0, 64'hA2, 32'd10, 3'd1, 8'h83, 32'd10, 8'd20, "R5 call equal, imm8 bit7");
    issue(1'b0, 64'hA3, 32'd11, 3'd5, 8'h00, 32'd10, 8'd40, "R4 call not taken");
    issue(1'b0, 64'hA4, 32'hFFFF_FFFF, 3'd2, 8'h00, 32'h7FFF_FFFF, 8'd41, "R2 unsigned compare");
    issue(1'b0, 64'hA5, 32'hFFFF_FFFF, 3'd6, 8'h7F, 32'd0, 8'd250, "R3 imm loc, R5 wrap");
    issue(1'b0, 64'hA6, 32'd99, 3'd7, 8'h00, 32'd1, 8'd255, "R6 push wrapped return");
    @(negedge clk);
    issue(1'b1, 64'hB0, 32'd7, 3'd4, 8'h00, 32'd6, 8'd9, "R4 ret compare fails");
    issue(1'b1, 64'hF0F0, 32'd0, 3'd6, 8'h00, 32'd0, 8'd10, "R8 pop newest");
    issue(1'b1, 64'hF1, 32'd0, 3'd0, 8'h00, 32'd0, 8'd11, "R8 pop second");
    issue(1'b1, 64'hF2, 32'd3, 3'd3, 8'h00, 32'd3, 8'd12, "R8 pop third");
    issue(1'b1, 64'hF3, 32'd0, 3'd7, 8'h00, 32'd0, 8'd13, "R8 pop last");
    issue(1'b1, 64'hC0, 32'd0, 3'd7, 8'h00, 32'd0, 8'd14, "R7 ret empty imm");
    issue(1'b1, 64'hC1, 32'd0, 3'd0, 8'h00, 32'd5, 8'd255, "R7 ret empty reg");
    repeat (2) @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      issue(1'b0, 64'h1000 + 64'(i), 32'd0, 3'd6, 8'(i), 32'd0, 8'(i * 7), "R10 back-to-back fill");
    end
    issue(1'b0, 64'hDEAD, 32'd0, 3'd6, 8'h10, 32'd0, 8'd77, "R9 call on full stack");
    issue(1'b1, 64'h5555, 32'd0, 3'd6, 8'h00, 32'd0, 8'd78, "R9 stack unchanged");
    issue(1'b0, 64'h7777, 32'd1, 3'd0, 8'h01, 32'd2, 8'd100, "R6 refill push");
    issue(1'b1, 64'h0, 32'd0, 3'd1, 8'h00, 32'd0, 8'd101, "R8 pop after refill");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R10 missing results got %0d pending expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule